// File: doc/BRIEF.md
# HDLC Transmit Stop Controller

This block is the control state machine for one HDLC transmit channel. It decides when the channel looks at its current transmit descriptor and when a frame starts and ends. It also handles three commands: an abrupt stop, a graceful stop and a restart. The serializer, the CRC logic and memory access are outside the block. The serializer reports each transmitted bit and the end of each frame. The block answers with fetch requests, a frame start, a descriptor-advance pulse, an abort-sequence request, a FIFO flush and a choice of line fill.

Once enabled, the channel polls its descriptor on a fixed period, 256 clocks by default. In on-demand mode it polls on every idle cycle instead. If the descriptor is ready when it is polled, a frame starts. An abrupt stop cuts the frame within a bounded number of transmitted bits. It then requests the abort byte (0x7F, sent by the serializer) and flushes the FIFO, and the descriptor pointer stays where it is. A graceful stop lets the current frame finish, advances the pointer and raises a sticky done event. Both stops end in a halted state, which only a restart command leaves.

All pins are plain control or status levels and single-cycle pulses. No data stream passes through the block, so it has no valid/ready handshake. Command pulses last one clock. Every output is a combinational function of the registered state and the current inputs, except `gra_done`, which is a register.

Top module: `hdlc_tx_stop_ctrl`

## Requirements
- R1: Out of reset, or with `chan_en` low, the block is off: no `fetch_req` and no fill outputs. When `chan_en` rises, the block enters the running state. With `on_demand` low it asserts `fetch_req` on the 256th cycle of the running state, and then every 256 cycles after that.
- R2: While running with no frame and `on_demand` high, `fetch_req` is asserted on every cycle.
- R3: `frame_start` is asserted only together with `fetch_req`, and only when `desc_ready` is high. The frame then runs until `frame_done`, which asserts `desc_advance` in that same cycle.
- R4: An abrupt stop (`cmd_stop`) during a frame asserts `abort_req` and `fifo_flush` on the 64th `bit_strobe` counted after the command cycle, or earlier if `frame_done` comes first. `desc_advance` is not asserted. An abrupt stop while running with no frame asserts `fifo_flush` without `abort_req`.
- R5: After an abrupt stop, `fetch_req` and `frame_start` stay low, whatever `on_demand` and `desc_ready` do, until a restart.
- R6: Outside a frame (running or halted), `fill_flags` is high when `idle_mode` is 0 and `fill_idles` is high when `idle_mode` is 1. Both are low while a frame is active and while the block is off.
- R7: A graceful stop (`cmd_graceful`) during a frame lets the frame run with no abort. At `frame_done` the block asserts `desc_advance` and halts, and `gra_done` is high from the next cycle. A graceful stop while running with no frame halts the block, and `gra_done` is high from the next cycle.
- R8: `cmd_restart` takes effect only in the halted state. It returns the block to running, where polling resumes, and a frame starts only when `desc_ready` is set at a poll.
- R9: `gra_done` is sticky. Pulsing `gra_clear` high clears it, unless a new set happens in the same cycle, in which case the set wins.
- R10: While halted, `cmd_stop` and `cmd_graceful` have no effect: no `abort_req`, no `fifo_flush`, and `gra_done` is not set.
- R11: An abrupt stop outranks a graceful stop, whether the graceful stop is pending or arrives in the same cycle. The frame is cut and aborted as in R4, and `gra_done` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable; low forces the off state |
| on_demand | input | 1 | Poll on every idle cycle instead of on the period |
| desc_ready | input | 1 | Ready bit of the current descriptor |
| bit_strobe | input | 1 | Serializer sent one bit this cycle |
| frame_done | input | 1 | Serializer finished the current frame |
| idle_mode | input | 1 | Line fill select: 0 flags, 1 idles |
| cmd_stop | input | 1 | Abrupt stop command pulse |
| cmd_graceful | input | 1 | Graceful stop command pulse |
| cmd_restart | input | 1 | Restart command pulse |
| gra_clear | input | 1 | Write-1 clear of `gra_done` |
| fetch_req | output | 1 | Descriptor poll this cycle |
| frame_start | output | 1 | Start a frame from the polled descriptor |
| desc_advance | output | 1 | Advance the descriptor pointer |
| abort_req | output | 1 | Send the abort byte 0x7F |
| fifo_flush | output | 1 | Flush the transmit FIFO |
| fill_flags | output | 1 | Line fills with flags |
| fill_idles | output | 1 | Line fills with idles |
| gra_done | output | 1 | Sticky graceful-stop-done event |

## Verification
The assertions check, on every cycle, that a frame starts only from a ready descriptor, that the halted state never polls and never sets the done event, that the done event stays set until it is cleared, and that the two fill selects never overlap. They also check that an abort never comes with a pointer advance or a fetch in the following cycle, and that a cut always fires by the 64th counted bit. Only the bench's scenarios show the exact poll period, the first poll after enable, the cut landing on exactly the 64th bit, restart being gated by the ready bit, and an abrupt stop winning over a pending graceful stop.

// File: rtl/hdlc_txc_pkg.sv
package hdlc_txc_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RUN   = 3'd1,
    ST_FRAME = 3'd2,
    ST_GRACE = 3'd3,
    ST_CUT   = 3'd4,
    ST_HALT  = 3'd5
  } txc_state_t;
endpackage

// File: rtl/hdlc_txc_poll_timer.sv
module hdlc_txc_poll_timer #(
  parameter int PERIOD = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/hdlc_txc_cut_counter.sv
module hdlc_txc_cut_counter #(
  parameter int CUT_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic bit_strobe,
  output logic limit_hit
);
  localparam int W = $clog2(CUT_BITS + 1);
  localparam logic [W-1:0] LAST = W'(CUT_BITS - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!arm)       cnt <= '0;
    else if (bit_strobe) cnt <= cnt + 1'b1;
  end

  assign limit_hit = arm && bit_strobe && (cnt == LAST);
endmodule

// File: rtl/hdlc_txc_event_bit.sv
module hdlc_txc_event_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clear,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= 1'b0;
    else if (set)   q <= 1'b1;
    else if (clear) q <= 1'b0;
  end
endmodule

// File: rtl/hdlc_tx_stop_ctrl.sv
module hdlc_tx_stop_ctrl
  import hdlc_txc_pkg::*;
#(
  parameter int POLL_PERIOD = 256,
  parameter int CUT_BITS    = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic on_demand,
  input  logic desc_ready,
  input  logic bit_strobe,
  input  logic frame_done,
  input  logic idle_mode,
  input  logic cmd_stop,
  input  logic cmd_graceful,
  input  logic cmd_restart,
  input  logic gra_clear,
  output logic fetch_req,
  output logic frame_start,
  output logic desc_advance,
  output logic abort_req,
  output logic fifo_flush,
  output logic fill_flags,
  output logic fill_idles,
  output logic gra_done
);
  txc_state_t state, state_nx;

  logic in_run, in_frame_like, poll_tick, limit_hit, cut_fire, gra_set, fill_on;

  assign in_run        = (state == ST_RUN);
  assign in_frame_like = (state == ST_FRAME) || (state == ST_GRACE);

  hdlc_txc_poll_timer #(.PERIOD(POLL_PERIOD)) u_poll (
    .clk(clk), .rst_n(rst_n), .run(in_run), .tick(poll_tick)
  );

  hdlc_txc_cut_counter #(.CUT_BITS(CUT_BITS)) u_cut (
    .clk(clk), .rst_n(rst_n), .arm(state == ST_CUT),
    .bit_strobe(bit_strobe), .limit_hit(limit_hit)
  );

  // Commands take precedence over a poll in the same cycle.
  assign fetch_req   = in_run && !cmd_stop && !cmd_graceful && (on_demand || poll_tick);
  assign frame_start = fetch_req && desc_ready;

  assign cut_fire     = (state == ST_CUT) && (limit_hit || frame_done);
  assign abort_req    = cut_fire;
  assign desc_advance = in_frame_like && frame_done;
  assign fifo_flush   = cut_fire
                      || (in_run && cmd_stop)
                      || (in_frame_like && frame_done && cmd_stop);

  assign gra_set = !cmd_stop && (
                     (in_run && cmd_graceful)
                   || ((state == ST_GRACE) && frame_done)
                   || ((state == ST_FRAME) && frame_done && cmd_graceful));

  hdlc_txc_event_bit u_gra (
    .clk(clk), .rst_n(rst_n), .set(gra_set), .clear(gra_clear), .q(gra_done)
  );

  assign fill_on    = in_run || (state == ST_HALT);
  assign fill_flags = fill_on && !idle_mode;
  assign fill_idles = fill_on && idle_mode;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_OFF:   if (chan_en) state_nx = ST_RUN;
      ST_RUN: begin
        if (cmd_stop || cmd_graceful) state_nx = ST_HALT;
        else if (frame_start)         state_nx = ST_FRAME;
      end
      ST_FRAME: begin
        if (frame_done)        state_nx = (cmd_stop || cmd_graceful) ? ST_HALT : ST_RUN;
        else if (cmd_stop)     state_nx = ST_CUT;
        else if (cmd_graceful) state_nx = ST_GRACE;
      end
      ST_GRACE: begin
        if (frame_done)    state_nx = ST_HALT;
        else if (cmd_stop) state_nx = ST_CUT;
      end
      ST_CUT:   if (cut_fire)    state_nx = ST_HALT;
      ST_HALT:  if (cmd_restart) state_nx = ST_RUN;
      default:  state_nx = ST_OFF;
    endcase
    if (!chan_en) state_nx = ST_OFF;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_OFF;
    else        state <= state_nx;
  end
endmodule

// File: rtl/hdlc_txc_checker.sv
module hdlc_txc_checker
  import hdlc_txc_pkg::*;
#(
  parameter int CUT_BITS = 64
) (
  input logic       clk,
  input logic       rst_n,
  input logic       chan_en,
  input logic       desc_ready,
  input logic       bit_strobe,
  input logic       frame_done,
  input logic       cmd_stop,
  input logic       gra_clear,
  input logic       fetch_req,
  input logic       frame_start,
  input logic       desc_advance,
  input logic       abort_req,
  input logic       fill_flags,
  input logic       fill_idles,
  input logic       gra_done,
  input txc_state_t state
);
  logic [15:0] strobes_in_cut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           strobes_in_cut <= '0;
    else if (state != ST_CUT)             strobes_in_cut <= '0;
    else if (bit_strobe)                  strobes_in_cut <= strobes_in_cut + 16'd1;
  end

  assert_disabled_no_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !fetch_req);

  assert_start_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (fetch_req && desc_ready));

  assert_cut_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CUT && bit_strobe && 32'(strobes_in_cut) == CUT_BITS - 1) |-> abort_req);

  assert_abort_then_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (!desc_advance && !fetch_req));

  assert_halt_no_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT) |-> (!fetch_req && !frame_start));

  assert_fill_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_flags && fill_idles));

  assert_gra_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gra_done && !gra_clear) |=> gra_done);

  assert_halt_no_gra_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HALT && !gra_done) |=> !gra_done);

  assert_stop_beats_grace_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_GRACE && cmd_stop && !frame_done && chan_en) |=> (state == ST_CUT));
endmodule

bind hdlc_tx_stop_ctrl hdlc_txc_checker #(.CUT_BITS(CUT_BITS)) u_txc_checker (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .desc_ready(desc_ready),
  .bit_strobe(bit_strobe), .frame_done(frame_done), .cmd_stop(cmd_stop),
  .gra_clear(gra_clear), .fetch_req(fetch_req), .frame_start(frame_start),
  .desc_advance(desc_advance), .abort_req(abort_req), .fill_flags(fill_flags),
  .fill_idles(fill_idles), .gra_done(gra_done), .state(state)
);

// File: tb/test_hdlc_tx_stop_ctrl.sv
`timescale 1ns/100ps
module test_hdlc_tx_stop_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 0, on_demand = 0, desc_ready = 0, bit_strobe = 0, frame_done = 0;
  logic idle_mode = 0, cmd_stop = 0, cmd_graceful = 0, cmd_restart = 0, gra_clear = 0;
  logic fetch_req, frame_start, desc_advance, abort_req, fifo_flush;
  logic fill_flags, fill_idles, gra_done;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  hdlc_tx_stop_ctrl i_hdlc_tx_stop_ctrl (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .on_demand(on_demand),
    .desc_ready(desc_ready), .bit_strobe(bit_strobe), .frame_done(frame_done),
    .idle_mode(idle_mode), .cmd_stop(cmd_stop), .cmd_graceful(cmd_graceful),
    .cmd_restart(cmd_restart), .gra_clear(gra_clear), .fetch_req(fetch_req),
    .frame_start(frame_start), .desc_advance(desc_advance), .abort_req(abort_req),
    .fifo_flush(fifo_flush), .fill_flags(fill_flags), .fill_idles(fill_idles),
    .gra_done(gra_done)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Ends at a falling edge; inputs driven here, outputs sampled after #1.
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic start_frame();
    on_demand = 1; desc_ready = 1;
    cyc();
    desc_ready = 0;
  endtask

  task automatic end_frame();
    frame_done = 1; cyc(); frame_done = 0;
  endtask

  task automatic restart();
    cmd_restart = 1; cyc(); cmd_restart = 0;
  endtask

  task automatic t_reset();
    #1;
    check("R1", "fetch after reset", fetch_req, 0);
    check("R1", "fill after reset", fill_flags | fill_idles, 0);
    check("R9", "gra_done after reset", gra_done, 0);
  endtask

  task automatic t_poll();
    int first = -1;
    int count = 0;
    chan_en = 1; on_demand = 0; desc_ready = 0;
    cyc();
    #1 check("R6", "flag fill while running", fill_flags, 1);
    for (int k = 0; k < 520; k++) begin
      #1;
      if (fetch_req) begin
        count++;
        if (first < 0) first = k;
      end
      cyc();
    end
    check("R1", "first poll cycle", first, 255);
    check("R1", "polls in 520 cycles", count, 2);
  endtask

  task automatic t_ondemand();
    on_demand = 1; #1;
    check("R2", "on-demand fetch", fetch_req, 1);
    check("R3", "no start without ready", frame_start, 0);
    desc_ready = 1; #1;
    check("R3", "start with ready", frame_start, 1);
    cyc(); desc_ready = 0; #1;
    check("R3", "no fetch inside frame", fetch_req, 0);
    check("R6", "no fill inside frame", fill_flags | fill_idles, 0);
    frame_done = 1; #1;
    check("R3", "advance at frame end", desc_advance, 1);
    cyc(); frame_done = 0; #1;
    check("R2", "fetch again after frame", fetch_req, 1);
  endtask

  task automatic t_abort();
    int first = -1;
    int adv = 0;
    int flush_ok = 0;
    int fetches = 0;
    start_frame();
    cmd_stop = 1; #1;
    check("R4", "no abort on command cycle", abort_req, 0);
    cyc(); cmd_stop = 0; bit_strobe = 1;
    for (int i = 1; i <= 70; i++) begin
      #1;
      if (abort_req && first < 0) begin first = i; flush_ok = fifo_flush; end
      if (desc_advance) adv++;
      cyc();
    end
    bit_strobe = 0;
    check("R4", "abort strobe index", first, 64);
    check("R4", "flush with abort", flush_ok, 1);
    check("R4", "no advance on abort", adv, 0);
    on_demand = 1; desc_ready = 1; idle_mode = 1;
    for (int i = 0; i < 300; i++) begin
      #1; if (fetch_req | frame_start) fetches++;
      cyc();
    end
    check("R5", "fetches while halted", fetches, 0);
    #1 check("R6", "idle fill while halted", fill_idles, 1);
    check("R6", "flag fill off", fill_flags, 0);
    desc_ready = 0; idle_mode = 0;
  endtask

  task automatic t_restart();
    on_demand = 1; desc_ready = 0;
    restart(); #1;
    check("R8", "fetch after restart", fetch_req, 1);
    check("R8", "no start until ready", frame_start, 0);
    cyc(); #1;
    check("R8", "still no start", frame_start, 0);
    desc_ready = 1; #1;
    check("R8", "start once ready", frame_start, 1);
    cyc(); desc_ready = 0;
    end_frame();
    cmd_stop = 1; #1;
    check("R4", "idle stop flushes", fifo_flush, 1);
    check("R4", "idle stop no abort", abort_req, 0);
    cyc(); cmd_stop = 0;
  endtask

  task automatic t_graceful_mid();
    int aborts = 0;
    restart();
    start_frame();
    cmd_graceful = 1; cyc(); cmd_graceful = 0; bit_strobe = 1;
    for (int i = 0; i < 80; i++) begin
      #1; if (abort_req) aborts++;
      cyc();
    end
    bit_strobe = 0;
    check("R7", "no abort during graceful", aborts, 0);
    check("R7", "gra_done before end", gra_done, 0);
    frame_done = 1; #1;
    check("R7", "advance at graceful end", desc_advance, 1);
    cyc(); frame_done = 0; #1;
    check("R7", "gra_done after end", gra_done, 1);
    check("R7", "halted after graceful", fetch_req, 0);
    repeat (5) cyc();
    #1 check("R9", "gra_done sticky", gra_done, 1);
    gra_clear = 1; cyc(); gra_clear = 0; #1;
    check("R9", "gra_done cleared", gra_done, 0);
  endtask

  task automatic t_graceful_idle();
    on_demand = 0; desc_ready = 0;
    restart();
    cmd_graceful = 1; cyc(); cmd_graceful = 0; #1;
    check("R7", "idle graceful sets done", gra_done, 1);
    gra_clear = 1; cyc(); gra_clear = 0;
    cmd_graceful = 1; #1;
    check("R10", "halted graceful flush", fifo_flush, 0);
    cyc(); cmd_graceful = 0; #1;
    check("R10", "halted graceful no done", gra_done, 0);
    cmd_stop = 1; #1;
    check("R10", "halted stop abort", abort_req, 0);
    check("R10", "halted stop flush", fifo_flush, 0);
    cyc(); cmd_stop = 0;
  endtask

  task automatic t_priority();
    int first = -1;
    restart();
    start_frame();
    cmd_graceful = 1; cyc(); cmd_graceful = 0;
    cmd_stop = 1; cyc(); cmd_stop = 0; bit_strobe = 1;
    for (int i = 1; i <= 66; i++) begin
      #1; if (abort_req && first < 0) first = i;
      cyc();
    end
    bit_strobe = 0;
    check("R11", "abort over pending graceful", first, 64);
    frame_done = 1; cyc(); frame_done = 0; #1;
    check("R11", "no gra_done after abort", gra_done, 0);
  endtask

  task automatic t_disable();
    restart();
    chan_en = 0; cyc(); #1;
    check("R1", "disabled fetch", fetch_req, 0);
    check("R1", "disabled fill", fill_flags | fill_idles, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_poll();
    t_ondemand();
    t_abort();
    t_restart();
    t_graceful_mid();
    t_graceful_idle();
    t_priority();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule